// File: doc/BRIEF.md
# Tight-Loop Fetch Suppression Unit

This unit sits between a 16-bit instruction fetch bus and a simple decoder. It watches the instruction stream for one pattern: a complete one-word instruction followed at once by a decrement-and-branch instruction whose displacement sends control back to that one-word instruction. The first pass through such a loop runs with ordinary fetching. When the branch is evaluated as taken with the matching displacement, the unit locks on. From then on it stops fetching opcodes and presents the two latched words, body then branch, to the decoder on every iteration. The unit evaluates the branch itself from a condition flag and the low 16 bits of a counter register, which the core supplies when the branch word is handed over. It writes the decremented count back through a write port.

The looped instruction may still make operand reads. These share the bus with fetches, always win arbitration, and pass through unchanged while loop mode is active. The loop ends when the condition is true, when the counter wraps, or when an abort arrives. On a normal exit, fetching resumes after the displacement word and the latched words are dropped. On an abort, fetching resumes at the word that was being handled.

Top module: `loop_fetch_sup`

## Requirements
- R1: After reset, `loop_on` and `dec_valid` are 0, no counter write is made, and a fetch request is made at `RESET_PC`.
- R2: A word with `dec_short`=1 at address A, a branch word at A+2 (bits 15:8 equal to `BR_OPC`), and the displacement 16'hFFFC at A+4 make `loop_on` rise after the first pass if the branch is taken. The word at A is fetched exactly once.
- R3: While `loop_on` is 1, no opcode fetch is placed on the bus (`bus_fetch`=0). The decoder receives the body word and the branch word alternately, with their own addresses.
- R4: An operand request (`op_req`) always takes the bus, in loop mode and out of it. While it is present, `bus_addr` equals `op_addr`, `bus_fetch` is 0, and `op_ack` follows `bus_ack`.
- R5: When the sampled condition is false, the unit writes the sampled count minus one. If the sampled count was 0, the write is 16'hFFFF and the loop ends, with fetching resuming at the branch word address plus 4.
- R6: When `br_cond` is 1 as the branch word is accepted, the loop ends at once with no counter write, on any pass including the first.
- R7: A taken branch with a displacement other than 16'hFFFC jumps to the displacement word address plus the sign-extended displacement and never sets `loop_on`.
- R8: If the word before the branch had `dec_short`=0, loop mode is not entered; every pass fetches the body again.
- R9: `abort` while `loop_on` is 1 clears `loop_on` on the next cycle without a counter write. The next fetch is at the address of the word in hand (`dec_pc`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | output | 1 | Bus cycle request |
| bus_fetch | output | 1 | Current bus request is an opcode fetch |
| bus_addr | output | AW | Bus byte address |
| bus_ack | input | 1 | Bus cycle completes this cycle |
| bus_rdata | input | 16 | Bus read data |
| op_req | input | 1 | Operand read request from the core |
| op_addr | input | AW | Operand address |
| op_ack | output | 1 | Operand read completes |
| op_rdata | output | 16 | Operand read data |
| dec_valid | output | 1 | Word offered to the decoder |
| dec_word | output | 16 | Offered instruction word |
| dec_pc | output | AW | Address of the offered or held word |
| dec_ready | input | 1 | Decoder accepts the word |
| dec_short | input | 1 | Offered word is a complete one-word instruction |
| br_cond | input | 1 | Branch condition is true (sampled with the branch word) |
| cnt_rd | input | 16 | Low half of the counter register |
| cnt_we | output | 1 | Counter write strobe |
| cnt_wd | output | 16 | Counter write value |
| abort | input | 1 | Force exit from loop mode |
| loop_on | output | 1 | Fetch suppression active |

## Verification
On every cycle, the assertions check that no opcode fetch appears while loop mode is active and that operand requests own the bus. They also check that an abort in loop mode clears it on the next cycle, that loop entry always follows a counter write, and that counter writes never come on consecutive cycles. Only the directed scenarios can show how many passes a loop makes and what final count it leaves. They also show the fall-through and jump addresses, that the body is fetched once, and that the unit refuses to engage for a wrong displacement or a multi-word body.

// File: rtl/loop_fetch_sup.sv
module loop_fetch_sup #(
  parameter int AW = 16,
  parameter logic [AW-1:0] RESET_PC = 16'h0010,
  parameter logic [7:0] BR_OPC = 8'h5C
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          bus_req,
  output logic          bus_fetch,
  output logic [AW-1:0] bus_addr,
  input  logic          bus_ack,
  input  logic [15:0]   bus_rdata,
  input  logic          op_req,
  input  logic [AW-1:0] op_addr,
  output logic          op_ack,
  output logic [15:0]   op_rdata,
  output logic          dec_valid,
  output logic [15:0]   dec_word,
  output logic [AW-1:0] dec_pc,
  input  logic          dec_ready,
  input  logic          dec_short,
  input  logic          br_cond,
  input  logic [15:0]   cnt_rd,
  output logic          cnt_we,
  output logic [15:0]   cnt_wd,
  input  logic          abort,
  output logic          loop_on
);
  localparam logic [15:0] LOOP_DISP = 16'hFFFC;
  localparam logic [AW-1:0] STEP = AW'(2);

  typedef enum logic [2:0] {S_FETCH, S_DEC, S_EVAL, S_BODY, S_BR} st_t;
  st_t st;

  logic [AW-1:0] pc, hold_pc, br_pc, body_pc;
  logic [15:0]   hold, br_word, body_word, cnt;
  logic          body_ok, want_disp, cnd, loop_q;

  wire fetch_go   = (st == S_FETCH) && !op_req;
  wire fetch_done = fetch_go && bus_ack;
  wire is_br      = hold[15:8] == BR_OPC;
  wire abort_hit  = abort && loop_q;
  wire leave      = cnd || (cnt == 16'h0000);
  wire [AW-1:0] fall   = br_pc + STEP + STEP;
  wire [AW-1:0] target = br_pc + STEP + AW'($signed(hold));
  wire qualify = body_ok && (hold == LOOP_DISP) && (body_pc == br_pc - STEP);

  assign bus_req   = op_req || (st == S_FETCH);
  assign bus_fetch = fetch_go;
  assign bus_addr  = op_req ? op_addr : pc;
  assign op_ack    = op_req && bus_ack;
  assign op_rdata  = bus_rdata;

  assign dec_valid = (st == S_DEC) || (st == S_BODY) || (st == S_BR);
  assign dec_word  = (st == S_BODY) ? body_word : (st == S_BR) ? br_word : hold;
  assign dec_pc    = (st == S_BODY) ? body_pc :
                     ((st == S_BR) || (st == S_EVAL)) ? br_pc : hold_pc;

  assign cnt_we  = (st == S_EVAL) && !cnd && !abort_hit;
  assign cnt_wd  = cnt - 16'd1;
  assign loop_on = loop_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_FETCH;
      pc        <= RESET_PC;
      hold      <= '0;
      hold_pc   <= '0;
      br_word   <= '0;
      br_pc     <= '0;
      body_word <= '0;
      body_pc   <= '0;
      body_ok   <= 1'b0;
      want_disp <= 1'b0;
      cnd       <= 1'b0;
      cnt       <= '0;
      loop_q    <= 1'b0;
    end else if (abort_hit) begin
      loop_q    <= 1'b0;
      body_ok   <= 1'b0;
      want_disp <= 1'b0;
      pc        <= dec_pc;
      st        <= S_FETCH;
    end else begin
      unique case (st)
        S_FETCH: if (fetch_done) begin
          hold      <= bus_rdata;
          hold_pc   <= pc;
          pc        <= pc + STEP;
          want_disp <= 1'b0;
          st        <= want_disp ? S_EVAL : S_DEC;
        end
        S_DEC: if (dec_ready) begin
          if (is_br) begin
            br_word   <= hold;
            br_pc     <= hold_pc;
            cnd       <= br_cond;
            cnt       <= cnt_rd;
            want_disp <= 1'b1;
          end else begin
            body_word <= hold;
            body_pc   <= hold_pc;
            body_ok   <= dec_short;
          end
          st <= S_FETCH;
        end
        S_EVAL: begin
          if (leave) begin
            pc      <= fall;
            loop_q  <= 1'b0;
            body_ok <= 1'b0;
            st      <= S_FETCH;
          end else if (qualify) begin
            loop_q <= 1'b1;
            st     <= S_BODY;
          end else begin
            pc      <= target;
            body_ok <= 1'b0;
            st      <= S_FETCH;
          end
        end
        S_BODY: if (dec_ready) st <= S_BR;
        S_BR: if (dec_ready) begin
          cnd  <= br_cond;
          cnt  <= cnt_rd;
          hold <= LOOP_DISP;
          st   <= S_EVAL;
        end
        default: st <= S_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/loop_fetch_sup_chk.sv
module loop_fetch_sup_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_fetch,
  input logic [AW-1:0] bus_addr,
  input logic          bus_ack,
  input logic          op_req,
  input logic [AW-1:0] op_addr,
  input logic          op_ack,
  input logic          cnt_we,
  input logic          abort,
  input logic          loop_on
);
  // R3
  no_fetch_in_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_on |-> !bus_fetch);

  // R4
  operand_owns_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_req |-> (bus_req && !bus_fetch && bus_addr == op_addr && op_ack == bus_ack));

  // R9
  abort_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_on && abort) |=> !loop_on);

  // R2
  entry_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_on) |-> $past(cnt_we));

  // R5
  single_write_per_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> !cnt_we);
endmodule

bind loop_fetch_sup loop_fetch_sup_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_fetch(bus_fetch),
  .bus_addr(bus_addr), .bus_ack(bus_ack), .op_req(op_req), .op_addr(op_addr),
  .op_ack(op_ack), .cnt_we(cnt_we), .abort(abort), .loop_on(loop_on)
);

// File: tb/loop_fetch_sup_tb.sv
`timescale 1ns/100ps
module loop_fetch_sup_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        bus_req, bus_fetch, op_ack, dec_valid, cnt_we, loop_on;
  logic [15:0] bus_addr, op_rdata, dec_word, dec_pc, cnt_wd, bus_rdata;
  logic        op_req = 1'b0, abort = 1'b0;
  logic [15:0] op_addr = '0;
  logic        dec_short, br_cond;
  logic [15:0] cnt_reg;
  logic [15:0] cnt_init = '0;
  int          cond_after = 1000;

  logic [15:0] mem [0:63];
  assign bus_rdata = mem[bus_addr[6:1]];
  assign dec_short = dec_word[15:12] == 4'h1;

  int br_count, f10, f0e, fl, nb, nw;
  logic loop_seen;
  assign br_cond = br_count >= cond_after;

  loop_fetch_sup u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_fetch(bus_fetch),
    .bus_addr(bus_addr), .bus_ack(1'b1), .bus_rdata(bus_rdata),
    .op_req(op_req), .op_addr(op_addr), .op_ack(op_ack), .op_rdata(op_rdata),
    .dec_valid(dec_valid), .dec_word(dec_word), .dec_pc(dec_pc),
    .dec_ready(1'b1), .dec_short(dec_short), .br_cond(br_cond),
    .cnt_rd(cnt_reg), .cnt_we(cnt_we), .cnt_wd(cnt_wd), .abort(abort),
    .loop_on(loop_on)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      cnt_reg <= cnt_init;
      br_count <= 0; f10 <= 0; f0e <= 0; fl <= 0; nb <= 0; nw <= 0;
      loop_seen <= 1'b0;
    end else begin
      if (cnt_we) begin cnt_reg <= cnt_wd; nw <= nw + 1; end
      if (dec_valid && dec_word[15:8] == 8'h5C) br_count <= br_count + 1;
      if (bus_fetch && bus_addr == 16'h0010) f10 <= f10 + 1;
      if (bus_fetch && bus_addr == 16'h000E) f0e <= f0e + 1;
      if (bus_fetch && loop_on) fl <= fl + 1;
      if (dec_valid && dec_pc == 16'h0010) nb <= nb + 1;
      if (loop_on) loop_seen <= 1'b1;
    end
  end

  int tests = 0, fails = 0;
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [15:0] body, input logic [15:0] disp);
    for (int i = 0; i < 64; i++) mem[i] = 16'h1000;
    mem[7] = 16'h1ABC;
    mem[8] = body;
    mem[9] = 16'h5C03;
    mem[10] = disp;
  endtask

  task automatic start(input logic [15:0] c, input int ca);
    @(negedge clk);
    rst_n = 1'b0; cnt_init = c; cond_after = ca;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_to(input logic [15:0] a, input string tag);
    int n = 0;
    while (!(dec_valid && dec_pc == a) && n < 3000) begin @(negedge clk); n++; end
    check(n < 3000, tag, n, 0);
  endtask

  task automatic t_reset;
    load(16'h1234, 16'hFFFC);
    @(negedge clk); rst_n = 1'b0; cnt_init = 16'h0003;
    @(negedge clk); @(negedge clk);
    // R1
    check(loop_on == 0 && dec_valid == 0 && cnt_we == 0, "R1 idle", loop_on, 0);
    check(bus_fetch == 1 && bus_addr == 16'h0010, "R1 fetch addr", bus_addr, 16'h0010);
    rst_n = 1'b1;
  endtask

  task automatic t_loop;
    load(16'h1234, 16'hFFFC);
    start(16'h0003, 1000);
    run_to(16'h0016, "R5 reach fall-through");
    check(f10 == 1, "R2 body fetched once", f10, 1);
    check(loop_seen, "R2 loop entered", loop_seen, 1);
    check(fl == 0, "R3 no fetch in loop", fl, 0);
    check(nb == 4, "R3 body replays", nb, 4);
    check(nw == 4 && cnt_reg == 16'hFFFF, "R5 wrap count", cnt_reg, 16'hFFFF);
    check(loop_on == 0, "R5 loop left", loop_on, 0);
  endtask

  task automatic t_wrap_first;
    load(16'h1234, 16'hFFFC);
    start(16'h0000, 1000);
    run_to(16'h0016, "R5 reach exit");
    check(nw == 1 && cnt_reg == 16'hFFFF, "R5 zero count", cnt_reg, 16'hFFFF);
    check(!loop_seen, "R5 no entry at zero", loop_seen, 0);
  endtask

  task automatic t_cond;
    load(16'h1234, 16'hFFFC);
    start(16'h0005, 2);
    run_to(16'h0016, "R6 reach exit");
    check(nw == 2 && cnt_reg == 16'h0003, "R6 count kept", cnt_reg, 16'h0003);
    check(nb == 3, "R6 passes", nb, 3);
    start(16'h0005, 0);
    run_to(16'h0016, "R6 reach exit first");
    check(nw == 0 && cnt_reg == 16'h0005 && !loop_seen, "R6 first pass true", cnt_reg, 16'h0005);
  endtask

  task automatic t_disp;
    load(16'h1234, 16'hFFFA);
    start(16'h0002, 1000);
    run_to(16'h0016, "R7 reach exit");
    check(f0e == 2, "R7 jump target", f0e, 2);
    check(!loop_seen, "R7 no entry", loop_seen, 0);
  endtask

  task automatic t_long;
    load(16'h2234, 16'hFFFC);
    start(16'h0002, 1000);
    run_to(16'h0016, "R8 reach exit");
    check(f10 == 3, "R8 body refetched", f10, 3);
    check(!loop_seen, "R8 no entry", loop_seen, 0);
  endtask

  task automatic t_op;
    load(16'h1234, 16'hFFFC);
    start(16'h0064, 1000);
    op_req = 1'b1; op_addr = 16'h0200; #1;
    check(bus_fetch == 0 && bus_addr == 16'h0200 && op_ack, "R4 before loop", bus_addr, 16'h0200);
    @(negedge clk); op_req = 1'b0;
    run_to(16'h0012, "R4 reach branch");
    while (!loop_on) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      op_req = 1'b1; op_addr = 16'h0240 + 16'(k); #1;
      check(bus_req && !bus_fetch && bus_addr == 16'h0240 + 16'(k) && op_ack,
            "R4 in loop", bus_addr, 16'h0240 + k);
      @(negedge clk);
    end
    op_req = 1'b0;
    run_to(16'h0016, "R4 loop completes");
    check(cnt_reg == 16'hFFFF, "R4 loop unaffected", cnt_reg, 16'hFFFF);
  endtask

  task automatic t_abort;
    logic [15:0] c0;
    int n = 0;
    load(16'h1234, 16'hFFFC);
    start(16'h0032, 1000);
    while (!(loop_on && dec_valid && dec_pc == 16'h0010 && nb >= 3) && n < 3000) begin
      @(negedge clk); n++;
    end
    c0 = cnt_reg;
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    // R9
    check(loop_on == 0, "R9 loop cleared", loop_on, 0);
    check(bus_fetch && bus_addr == 16'h0010, "R9 refetch addr", bus_addr, 16'h0010);
    check(cnt_reg == c0, "R9 no write", cnt_reg, c0);
  endtask

  initial begin
    int cyc = 0;
    fork
      begin
        t_reset(); t_loop(); t_wrap_first(); t_cond(); t_disp();
        t_long(); t_op(); t_abort();
      end
      begin
        while (cyc < 100000) begin @(posedge clk); cyc++; end
        check(0, "watchdog", cyc, 0);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule